// File: doc/BRIEF.md
# Amplifier Control Command Port (I2C, write-only)

This block is a small I2C target that sits beside a speaker amplifier and turns single-byte write transfers into two pieces of control state. One is a 6-bit volume level. The other is the choice between two output modulation schemes. A system clock samples SCL and SDA through two-stage synchronizers. Edge detection on the synchronized lines finds START, repeated START and STOP conditions. A frame engine then collects the address byte and the command byte, and acknowledges each one by enabling an open-drain pull-down on SDA.

The 7-bit address has a fixed upper part. Its two low bits come from two strap pins. When both straps are tied low the serial port is switched off completely, so three addresses are usable. A command byte whose two top bits are zero is a volume write. Two fixed codes pick the modulation scheme. Any other code is acknowledged and has no effect. Each accepted change raises a one-cycle strobe. Reset is the only thing that clears the stored state. Amplifier shutdown does not touch it.

Top module: `amp_i2c_ctrl`

## Requirements
- R1: After reset the volume output is 0 (mute), the modulation output is 1 (filterless), and both the strobe and the SDA pull-down are 0.
- R2: With straps not 00, an address byte equal to {1,0,0,1,0,strap[1],strap[0]} followed by a write bit of 0 is acknowledged. The pull-down is on during the whole high phase of the 9th SCL clock and is released after that clock falls.
- R3: An address byte that does not match, or that carries a read bit (1), is not acknowledged. The command byte that follows it is not acknowledged either and changes no output.
- R4: With strap = 00 no byte is ever acknowledged and no output changes.
- R5: In an addressed frame, a command byte with bits 7:6 = 00 loads bits 5:0 into the volume output. The modulation output is unchanged.
- R6: Command 0xD5 sets the modulation output to 0 (classic PWM) and command 0xD6 sets it to 1 (filterless). The volume output is unchanged.
- R7: Any other command byte is acknowledged but changes no output and raises no strobe.
- R8: Each volume or mode write raises the strobe for exactly one clock. Volume and mode outputs change only in a cycle where the strobe is high.
- R9: A STOP at any bit position ends the frame. A partially received byte is discarded, and a following frame is handled normally.
- R10: A repeated START at any point restarts address reception, and the new frame is handled normally.
- R11: After the command byte, further bytes in the same frame are neither acknowledged nor applied.
- R12: An SDA rise that falls in the same SCL high phase as the START is not taken as STOP. The frame continues and is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_strap | input | 2 | Address strap pins; bit 1 is address bit 1, bit 0 is address bit 0; 00 disables the port |
| sda_pull | output | 1 | Open-drain pull-down enable for SDA |
| vol_level | output | 6 | Volume code, 0 means mute |
| mode_filterless | output | 1 | 1 selects filterless modulation, 0 classic PWM |
| wr_strobe | output | 1 | One-cycle pulse on each applied write |

## Verification
The hardest case to reach from the pins is the SDA rise that falls in the same SCL high phase as a START. A normal master never makes this edge. The bench builds it on purpose by raising SDA again before SCL falls, then sends a valid address and command, and expects the frame to be acknowledged and applied. The same directed style covers STOPs cut in mid-byte and repeated STARTs that follow a rejected address. Random frames mix matching and non-matching addresses, read bits and all command classes across the three enabled straps, and a reference model predicts each acknowledge and each output change.

// File: rtl/amp_i2c_pkg.sv
// Package: shared constants and types for the amplifier command port.
// Assumes an 8-bit byte and a 5-bit fixed address prefix.
package amp_i2c_pkg;

    localparam int BYTE_W  = 8;
    localparam int VOL_W   = 6;
    localparam int STRAP_W = 2;

    localparam logic [4:0] ADDR_PREFIX = 5'b10010;
    localparam logic [7:0] CODE_PWM    = 8'hD5;
    localparam logic [7:0] CODE_FLESS  = 8'hD6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_HOLD
    } frame_state_t;

endpackage

// File: rtl/amp_i2c_sync.sv
// Module: two-flop synchronizers for SCL/SDA plus bus-event detection.
// Assumes clk is at least 25x the SCL rate. Reset sets both lines to idle-high.
module amp_i2c_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] scl_pipe;
    logic [1:0] sda_pipe;
    logic       scl_d;
    logic       sda_d;

    // Purpose: bring the line levels into clk and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= 2'b11;
            sda_pipe <= 2'b11;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[0], scl_i};
            sda_pipe <= {sda_pipe[0], sda_i};
            scl_d    <= scl_pipe[1];
            sda_d    <= sda_pipe[1];
        end
    end

    assign scl_s = scl_pipe[1];
    assign sda_s = sda_pipe[1];

    // Purpose: classify SCL edges and SDA edges that occur while SCL is high.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/amp_i2c_frame.sv
// Module: frame engine. It receives the address and command bytes,
// drives the acknowledge, and hands each accepted command byte onward.
// Assumes that SCL and SDA are already synchronized and that events are
// one-cycle pulses.
module amp_i2c_frame
    import amp_i2c_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int SW = STRAP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] strap,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    output logic          sda_pull,
    output logic          cmd_valid,
    output logic [BW-1:0] cmd_byte
);

    localparam int CW = $clog2(BW + 1);

    frame_state_t  state;
    logic [CW-1:0] bit_cnt;
    logic [BW-1:0] shreg;
    logic          start_hi;
    logic          bus_en;
    logic          addr_ok;
    logic          byte_done;

    // Purpose: straps at zero switch the port off; compare the address byte.
    always_comb begin
        bus_en    = (strap != '0);
        addr_ok   = (shreg[BW-1:1] == {ADDR_PREFIX, strap}) && !shreg[0];
        byte_done = scl_fall && (bit_cnt == CW'(BW));
    end

    // Purpose: frame sequencing, bit shifting and acknowledge control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            start_hi  <= 1'b0;
            sda_pull  <= 1'b0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (!bus_en) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                start_hi <= 1'b0;
            end else if (start_det) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
                start_hi <= 1'b1;
            end else if (stop_det && !start_hi) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                if (scl_fall) start_hi <= 1'b0;
                case (state)
                    ST_ADDR, ST_CMD: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BW-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_CMD) begin
                                state     <= ST_CMD_ACK;
                                sda_pull  <= 1'b1;
                                cmd_valid <= 1'b1;
                            end else if (addr_ok) begin
                                state    <= ST_ADDR_ACK;
                                sda_pull <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            state    <= ST_CMD;
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                        end
                    end
                    ST_CMD_ACK: begin
                        if (scl_fall) begin
                            state    <= ST_HOLD;
                            sda_pull <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign cmd_byte = shreg;

endmodule

// File: rtl/amp_i2c_cmdreg.sv
// Module: command decoder and control registers. It holds the volume and
// modulation select, and pulses a strobe on each applied write.
// Assumes that cmd_valid is a single-cycle pulse.
module amp_i2c_cmdreg
    import amp_i2c_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int VW = VOL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [BW-1:0] cmd_byte,
    output logic [VW-1:0] vol_level,
    output logic          mode_filterless,
    output logic          wr_strobe
);

    localparam int SEL_W = BW - VW;

    logic is_vol;
    logic is_pwm;
    logic is_fless;

    // Purpose: sort the command byte into its three classes.
    always_comb begin
        is_vol   = (cmd_byte[BW-1 -: SEL_W] == '0);
        is_pwm   = (cmd_byte == CODE_PWM);
        is_fless = (cmd_byte == CODE_FLESS);
    end

    // Purpose: apply recognized commands and raise the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_level       <= '0;
            mode_filterless <= 1'b1;
            wr_strobe       <= 1'b0;
        end else begin
            wr_strobe <= 1'b0;
            if (cmd_valid) begin
                if (is_vol) begin
                    vol_level <= cmd_byte[VW-1:0];
                    wr_strobe <= 1'b1;
                end else if (is_pwm || is_fless) begin
                    mode_filterless <= is_fless;
                    wr_strobe       <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/amp_i2c_ctrl.sv
// Module: top of the write-only amplifier command port.
// Assumes that clk is at least 10 MHz for a 400 kHz bus and that the straps
// change only while the bus is idle.
module amp_i2c_ctrl
    import amp_i2c_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] addr_strap,
    output logic               sda_pull,
    output logic [VOL_W-1:0]   vol_level,
    output logic               mode_filterless,
    output logic               wr_strobe
);

    logic              scl_sync;
    logic              sda_sync;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              cmd_valid;
    logic [BYTE_W-1:0] cmd_byte;

    amp_i2c_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_sync),
        .sda_s     (sda_sync),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    amp_i2c_frame #(.BW(BYTE_W), .SW(STRAP_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap     (addr_strap),
        .sda_s     (sda_sync),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_pull  (sda_pull),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte)
    );

    amp_i2c_cmdreg #(.BW(BYTE_W), .VW(VOL_W)) u_cmdreg (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmd_valid       (cmd_valid),
        .cmd_byte        (cmd_byte),
        .vol_level       (vol_level),
        .mode_filterless (mode_filterless),
        .wr_strobe       (wr_strobe)
    );

endmodule

// File: rtl/amp_i2c_ctrl_chk.sv
// Module: property checker bound to amp_i2c_ctrl.
// Assumes a synchronous active-low reset.
module amp_i2c_ctrl_chk
    import amp_i2c_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               scl_s,
    input logic [STRAP_W-1:0] addr_strap,
    input logic               sda_pull,
    input logic [VOL_W-1:0]   vol_level,
    input logic               mode_filterless,
    input logic               wr_strobe
);

    // R8: the strobe never lasts longer than one clock
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    // R5: the volume moves only together with the strobe
    assert_vol_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vol_level) |-> wr_strobe);

    // R6: the modulation select moves only together with the strobe
    assert_mode_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_filterless) |-> wr_strobe);

    // R4: a disabled port never pulls SDA
    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strap == '0) |-> !sda_pull);

    // R2: the acknowledge starts while SCL is low
    assert_ack_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    // R2: the acknowledge ends while SCL is low
    assert_ack_release_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> !scl_s);

endmodule

bind amp_i2c_ctrl amp_i2c_ctrl_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_s           (scl_sync),
    .addr_strap      (addr_strap),
    .sda_pull        (sda_pull),
    .vol_level       (vol_level),
    .mode_filterless (mode_filterless),
    .wr_strobe       (wr_strobe)
);

// File: tb/test_amp_i2c_ctrl.sv
`timescale 1ns/1ps
module test_amp_i2c_ctrl;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap = 2'b01;
    logic       sda_pull;
    logic [5:0] vol_level;
    logic       mode_filterless;
    logic       wr_strobe;
    logic       sda_line;

    int total = 0;
    int bad = 0;
    int strobe_cnt = 0;

    logic [5:0] e_vol = 6'd0;
    logic       e_mode = 1'b1;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    amp_i2c_ctrl i_amp_i2c_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl),
        .sda_i           (sda_line),
        .addr_strap      (strap),
        .sda_pull        (sda_pull),
        .vol_level       (vol_level),
        .mode_filterless (mode_filterless),
        .wr_strobe       (wr_strobe)
    );

    always @(negedge clk) if (rst_n && wr_strobe) strobe_cnt <= strobe_cnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        m_sda = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        m_sda = 1'b1; wq(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wq(Q);
            scl = 1'b1;   wq(2*Q);
            scl = 1'b0;   wq(Q);
        end
    endtask

    // Sends one byte and samples the pull-down in the 9th clock high phase.
    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_sda = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        ack = sda_pull;
        wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    function automatic logic [7:0] addr_of(input logic [1:0] s, input bit rd);
        return {5'b10010, s, rd};
    endfunction

    function automatic bit is_write(input logic [7:0] c);
        return (c[7:6] == 2'b00) || (c == 8'hD5) || (c == 8'hD6);
    endfunction

    task automatic model_apply(input logic [7:0] c);
        if (c[7:6] == 2'b00) e_vol = c[5:0];
        else if (c == 8'hD5) e_mode = 1'b0;
        else if (c == 8'hD6) e_mode = 1'b1;
    endtask

    task automatic check_outs(input string req);
        chk(vol_level == e_vol, {req, " vol"}, vol_level, e_vol);
        chk(mode_filterless == e_mode, {req, " mode"}, mode_filterless, e_mode);
    endtask

    // Full frame: address, command, stop, checked against the model.
    task automatic frame(input logic [7:0] a, input logic [7:0] c, input string req);
        bit a_ack, c_ack, exp_a;
        int s0;
        s0 = strobe_cnt;
        exp_a = (strap != 2'b00) && (a == addr_of(strap, 1'b0));
        bus_start();
        send_byte(a, a_ack);
        send_byte(c, c_ack);
        bus_stop();
        chk(a_ack == exp_a, {req, " addr ack"}, a_ack, exp_a);
        chk(c_ack == exp_a, {req, " cmd ack"}, c_ack, exp_a);
        if (exp_a) model_apply(c);
        check_outs(req);
        chk(strobe_cnt - s0 == int'(exp_a && is_write(c)), {req, " strobe R8"},
            strobe_cnt - s0, int'(exp_a && is_write(c)));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit ack;
        int s0;
        void'($urandom(32'd4242));
        wq(5);
        // R1: reset state
        chk(vol_level == 6'd0, "R1 vol", vol_level, 0);
        chk(mode_filterless == 1'b1, "R1 mode", mode_filterless, 1);
        chk(wr_strobe == 1'b0, "R1 strobe", wr_strobe, 0);
        chk(sda_pull == 1'b0, "R1 pull", sda_pull, 0);
        rst_n = 1'b1;
        wq(5);

        // R2, R5: basic volume write on each enabled strap
        strap = 2'b01; frame(addr_of(2'b01, 0), 8'h2A, "R2 R5 s01");
        strap = 2'b10; frame(addr_of(2'b10, 0), 8'h3F, "R2 R5 s10");
        strap = 2'b11; frame(addr_of(2'b11, 0), 8'h00, "R2 R5 s11");
        // R6: mode codes
        frame(addr_of(2'b11, 0), 8'hD5, "R6 pwm");
        frame(addr_of(2'b11, 0), 8'hD6, "R6 fless");
        frame(addr_of(2'b11, 0), 8'hD5, "R6 pwm again");
        // R7: unknown codes
        frame(addr_of(2'b11, 0), 8'h40, "R7 0x40");
        frame(addr_of(2'b11, 0), 8'hD7, "R7 0xD7");
        // R3: mismatch and read bit
        frame(addr_of(2'b10, 0), 8'h11, "R3 wrong strap");
        frame(addr_of(2'b11, 1), 8'h12, "R3 read bit");
        frame(8'h26, 8'h13, "R3 wrong prefix");
        // R4: disabled port
        strap = 2'b00;
        frame(addr_of(2'b00, 0), 8'h14, "R4 disabled");
        strap = 2'b01;

        // R9: stop inside the command byte
        s0 = strobe_cnt;
        bus_start();
        send_byte(addr_of(2'b01, 0), ack);
        send_bits(8'h05, 4);
        bus_stop();
        check_outs("R9 partial");
        chk(strobe_cnt == s0, "R9 strobe", strobe_cnt - s0, 0);
        frame(addr_of(2'b01, 0), 8'h15, "R9 after");

        // R10: repeated start after a rejected address
        bus_start();
        send_byte(addr_of(2'b10, 0), ack);
        chk(ack == 1'b0, "R10 first addr", ack, 0);
        bus_start();
        send_byte(addr_of(2'b01, 0), ack);
        chk(ack == 1'b1, "R10 restart addr", ack, 1);
        send_byte(8'h09, ack);
        bus_stop();
        model_apply(8'h09);
        check_outs("R10");

        // R11: an extra byte after the command
        bus_start();
        send_byte(addr_of(2'b01, 0), ack);
        send_byte(8'h05, ack);
        send_byte(8'h07, ack);
        chk(ack == 1'b0, "R11 extra ack", ack, 0);
        bus_stop();
        model_apply(8'h05);
        check_outs("R11");

        // R12: SDA rises again in the high phase of the START
        m_sda = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        m_sda = 1'b0; wq(Q);
        m_sda = 1'b1; wq(Q);
        scl = 1'b0;   wq(Q);
        send_byte(addr_of(2'b01, 0), ack);
        chk(ack == 1'b1, "R12 addr ack", ack, 1);
        send_byte(8'h21, ack);
        bus_stop();
        model_apply(8'h21);
        check_outs("R12");

        // Random frames across R2 R3 R5 R6 R7
        for (int k = 0; k < 50; k++) begin
            logic [7:0] a, c;
            int p;
            strap = 2'($urandom_range(1, 3));
            p = $urandom_range(0, 9);
            if (p < 7) a = addr_of(strap, 0);
            else if (p == 7) a = addr_of(strap, 1);
            else a = addr_of(~strap, 0);
            p = $urandom_range(0, 9);
            if (p < 5) c = {2'b00, 6'($urandom)};
            else if (p == 5) c = 8'hD5;
            else if (p == 6) c = 8'hD6;
            else c = 8'($urandom);
            frame(a, c, "R2 R3 R5 R6 R7 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule